// File: doc/BRIEF.md
# Per-Chip-Select Wait-State Generator

This block paces external bus cycles for four chip-select spaces. A single 16-bit configuration word holds a 3-bit data-wait count for each space. When a bus cycle begins, the block decodes the address and picks one of three outcomes. Internal ROM and RAM accesses complete at once. Peripheral-region accesses are governed only by the peripheral's own ready signal. External accesses drive the matching chip-select line and stretch the data phase by that space's programmed count before raising ready for one clock.

A bus cycle starts when `bus_start` is high at a clock edge and no other cycle is in flight. The cycle in which `bus_start` is sampled is called cycle T. The data clocks follow from T+1 onward. The configuration word is read and written only as a whole word through a small register port with a combinational read path.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset the configuration word reads 0x7777, `bus_ready` is low and `cs_sel` is all zero.
- R2: A write loads the configuration word as a full 16-bit value. Bits 3, 7, 11 and 15 always read 0, whatever the write data.
- R3: The wait count for each space sits in a fixed field: CS0 in bits 2:0, CS1 in bits 6:4, CS2 in bits 10:8 and CS3 in bits 14:12. An external access started in cycle T with count N raises `bus_ready` in cycle T+1+N, for exactly one clock.
- R4: A count of 0 raises `bus_ready` in cycle T+1, the first data clock.
- R5: Accesses to internal ROM (0x000000 to 0x03FFFF) and internal RAM (0x0F0000 to 0x0F3FFF) raise `bus_ready` in cycle T+1 whatever the configuration holds, and drive no chip select.
- R6: During an access to the peripheral region (0x0FF000 to 0x0FFFFF), `bus_ready` equals `per_ready` from cycle T+1 on. The cycle ends in the first clock in which `per_ready` is high. No chip select is driven.
- R7: The wait count is captured at the start edge. A configuration write in the start cycle, or in any later cycle of that access, does not change the length of the access.
- R8: External addresses decode into four 1 MiB regions from 0x100000: CS0, CS1, CS2, then CS3. Any address outside every mapped region uses CS3 and its count. `cs_sel` is one-hot with bit n for CSn, from T+1 through the ready cycle inclusive, and zero otherwise.
- R9: `bus_start` is ignored while an access is in flight. A start in the ready cycle of the previous access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current configuration word |
| bus_start | input | 1 | Start of a bus cycle, qualified with `bus_addr` |
| bus_addr | input | ADDR_W | Address of the starting bus cycle |
| per_ready | input | 1 | Ready signal from the addressed peripheral |
| bus_ready | output | 1 | Data phase may complete |
| cs_sel | output | 4 | One-hot chip select of the active external access |

## Verification
Two kinds of event can land on the same clock edge. A configuration write can coincide with the start of an access, or with any of its wait clocks. A new start can coincide with the ready cycle that ends the previous access. The bench provokes both. It writes a new count in the exact cycle that `bus_start` is sampled, and it issues starts both mid-wait and in the ready cycle. Its behavioural model takes the count from the word as it stood before the write, and it accepts a start only once the previous access has reached its ready cycle. Every cycle, it compares ready timing and chip-select against that model.

// File: rtl/cs_wait_gen.sv
module cs_wait_gen #(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 'h000000,
  parameter logic [ADDR_W-1:0] ROM_SIZE  = 'h040000,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 'h0F0000,
  parameter logic [ADDR_W-1:0] RAM_SIZE  = 'h004000,
  parameter logic [ADDR_W-1:0] PER_BASE  = 'h0FF000,
  parameter logic [ADDR_W-1:0] PER_SIZE  = 'h001000,
  parameter logic [ADDR_W-1:0] EXT_BASE  = 'h100000,
  parameter int                EXT_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              per_ready,
  output logic              bus_ready,
  output logic [3:0]        cs_sel
);
  localparam logic [15:0]       CFG_MASK = 16'h7777;
  localparam logic [15:0]       CFG_RST  = 16'h7777;
  localparam logic [ADDR_W-1:0] EXT_SPAN = ADDR_W'(4) << EXT_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PER} st_t;

  st_t               st;
  logic [15:0]       cfg;
  logic [2:0]        cnt;
  logic              rdy_q;
  logic [3:0]        cs_q;
  logic [ADDR_W-1:0] rom_off, ram_off, per_off, ext_off;
  logic              hit_mem, hit_per, hit_ext;
  logic [1:0]        cs_idx;
  logic [2:0]        sel_wait;
  logic              accept, per_cyc, wait_cyc;

  assign rom_off  = bus_addr - ROM_BASE;
  assign ram_off  = bus_addr - RAM_BASE;
  assign per_off  = bus_addr - PER_BASE;
  assign ext_off  = bus_addr - EXT_BASE;
  assign hit_mem  = (rom_off < ROM_SIZE) | (ram_off < RAM_SIZE);
  assign hit_per  = ~hit_mem & (per_off < PER_SIZE);
  assign hit_ext  = ext_off < EXT_SPAN;
  assign cs_idx   = hit_ext ? ext_off[EXT_SHIFT+1:EXT_SHIFT] : 2'd3;
  assign sel_wait = cfg[{cs_idx, 2'b00} +: 3];

  assign per_cyc  = (st == S_PER);
  assign wait_cyc = (st == S_WAIT);
  assign accept   = bus_start & ((st == S_IDLE) | (per_cyc & per_ready));

  assign reg_rdata = cfg;
  assign bus_ready = rdy_q | (per_cyc & per_ready);
  assign cs_sel    = cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= CFG_RST;
    else if (reg_we) cfg <= reg_wdata & CFG_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      rdy_q <= 1'b0;
      cs_q  <= '0;
    end else begin
      rdy_q <= 1'b0;
      if (accept) begin
        cs_q <= (hit_mem | hit_per) ? 4'b0000 : (4'b0001 << cs_idx);
        if (hit_per) begin
          st <= S_PER;
        end else if (hit_mem || sel_wait == 3'd0) begin
          st    <= S_IDLE;
          rdy_q <= 1'b1;
        end else begin
          st  <= S_WAIT;
          cnt <= sel_wait - 3'd1;
        end
      end else begin
        case (st)
          S_WAIT: begin
            if (cnt == 3'd0) begin
              rdy_q <= 1'b1;
              st    <= S_IDLE;
            end else begin
              cnt <= cnt - 3'd1;
            end
          end
          S_PER:   if (per_ready) st <= S_IDLE;
          default: if (rdy_q) cs_q <= '0;
        endcase
      end
    end
  end
endmodule

module cs_wait_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] reg_rdata,
  input logic        bus_ready,
  input logic [3:0]  cs_sel,
  input logic        per_ready,
  input logic        per_cyc,
  input logic        wait_cyc,
  input logic        accept,
  input logic        hit_mem
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'h8888) == 16'h0000);
  a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));
  a_r6_per_follow: assert property (@(posedge clk) disable iff (!rst_n)
    per_cyc |-> (bus_ready == per_ready) && (cs_sel == 4'b0000));
  a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cyc |-> (cs_sel != 4'b0000) && !bus_ready);
  a_r5_mem_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_mem) |=> bus_ready && (cs_sel == 4'b0000));
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cyc |=> $stable(cs_sel));
endmodule

bind cs_wait_gen cs_wait_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .bus_ready(bus_ready),
  .cs_sel(cs_sel), .per_ready(per_ready), .per_cyc(per_cyc),
  .wait_cyc(wait_cyc), .accept(accept), .hit_mem(hit_mem)
);

// File: tb/tb_cs_wait_gen.sv
module tb_cs_wait_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_start = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        per_ready = 1'b0;
  logic        bus_ready;
  logic [3:0]  cs_sel;

  cs_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_start(bus_start), .bus_addr(bus_addr),
    .per_ready(per_ready), .bus_ready(bus_ready), .cs_sel(cs_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  int          cyc = 0;
  int          kind = 0;
  int          ready_at = 0;
  logic [3:0]  cur_cs = '0;
  logic [15:0] mcfg = 16'h7777;

  function automatic int region(input logic [23:0] a);
    if (a < 24'h040000) return 4;
    if (a >= 24'h0F0000 && a < 24'h0F4000) return 4;
    if (a >= 24'h0FF000 && a < 24'h100000) return 5;
    if (a >= 24'h100000 && a < 24'h500000) return int'((a - 24'h100000) >> 20);
    return 3;
  endfunction

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic tick(input logic s, input logic [23:0] a, input logic p,
                      input logic w, input logic [15:0] d);
    logic       exp_rdy;
    logic [3:0] exp_cs;
    logic       acc;
    int         r, n;
    @(posedge clk);
    #1;
    bus_start = s; bus_addr = a; per_ready = p; reg_we = w; reg_wdata = d;
    @(negedge clk);
    exp_rdy = (kind == 1 && cyc == ready_at) || (kind == 2 && p);
    exp_cs  = (kind == 1 && cyc <= ready_at) ? cur_cs : 4'b0000;
    chk("bus_ready", {15'b0, bus_ready}, {15'b0, exp_rdy});
    chk("cs_sel", {12'b0, cs_sel}, {12'b0, exp_cs});
    chk("reg_rdata", reg_rdata, mcfg);
    acc = s && (kind == 0 || (kind == 1 && cyc >= ready_at) || (kind == 2 && p));
    if (kind == 2 && p) kind = 0;
    if (acc) begin
      r = region(a);
      if (r == 5) begin
        kind = 2; cur_cs = '0;
      end else begin
        n = (r == 4) ? 0 : int'(mcfg[r*4 +: 3]);
        kind = 1; ready_at = cyc + 1 + n;
        cur_cs = (r < 4) ? (4'b0001 << r) : 4'b0000;
      end
    end
    if (w) mcfg = d & 16'h7777;
    cyc++;
  endtask

  function automatic bit busy();
    return (kind == 2) || (kind == 1 && cyc < ready_at);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, '0, 0, 0, '0);
  endtask

  task automatic wr(input logic [15:0] d);
    tick(0, '0, 0, 1, d);
  endtask

  task automatic access(input logic [23:0] a);
    tick(1, a, 0, 0, '0);
    for (int i = 0; i < 12 && (busy() || kind == 1 && cyc == ready_at); i++)
      tick(0, '0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1"; idle(3);
    tag = "R3"; access(24'h100040);
    tag = "R2"; wr(16'hFFFF); wr(16'h1234); wr(16'h8888); wr(16'h0000); idle(1);
    tag = "R4"; access(24'h300000); access(24'h100000);
    tag = "R3"; wr(16'h3521);
    access(24'h100010); access(24'h200020); access(24'h300030); access(24'h400040);
    tag = "R5"; wr(16'h7777);
    access(24'h000100); access(24'h03FFFF); access(24'h0F3FFC);
    tag = "R6";
    tick(1, 24'h0FF010, 0, 0, '0);
    tick(0, '0, 0, 0, '0); tick(0, '0, 0, 0, '0); tick(0, '0, 0, 0, '0);
    tick(0, '0, 1, 0, '0); idle(2);
    tick(1, 24'h0FF800, 1, 0, '0); tick(1, 24'h200000, 1, 0, '0); idle(9);
    tag = "R7"; wr(16'h0060);
    tick(1, 24'h200000, 0, 0, '0); tick(0, '0, 0, 1, 16'h0000); idle(8);
    wr(16'h0005); tick(1, 24'h100000, 0, 1, 16'h0000); idle(7);
    tag = "R8"; wr(16'h2000);
    access(24'h800000); access(24'h050000); access(24'h0FE000); access(24'h4FFFFF);
    tag = "R9"; wr(16'h0002);
    tick(1, 24'h100000, 0, 0, '0);
    tick(1, 24'h200000, 0, 0, '0);
    tick(1, 24'h300000, 0, 0, '0);
    tick(1, 24'h200000, 0, 0, '0);
    tick(1, 24'h000000, 0, 0, '0);
    idle(4);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule